// File: doc/BRIEF.md
# Multi-Mode Capture Timer

An 8-bit down-counting timer with a reload latch, meant to sit beside a small processor core. A 2-bit mode field selects one of four uses of the same counter. It can run as a free-running interval timer. It can measure the period of an external pin signal, count edges on that pin, or measure the high and low phases of the pin one after another. Each time the counter wraps below zero it reloads from the latch and raises a timer interrupt-request flag. Selected pin edges raise a separate pin interrupt-request flag.

The counter clock comes from a small prescaler. It can be the main clock divided by 16, the main clock divided by 2, or an enable input that stands in for an on-chip oscillator, or it can be switched off. In the two measurement modes a trigger edge copies the running count into a capture register and restarts the counter from the latch. That capture is then frozen until the processor reads the count once. Software writes the mode register, the source register and the reload value through write strobes. It reads them back through plain output ports and releases a held capture with a read strobe.

Top module: `cap_timer`

## Requirements
- R1: After reset the mode and source registers read 00h, the count reads FFh and both request flags are 0.
- R2: Only mode bits [3:0] and source bits [1:0] are stored; all other read-back bits are 0. Mode bits: [1:0] mode (00 timer, 01 period, 10 event, 11 high/low width), bit 2 edge select, bit 3 stop.
- R3: With stop = 1 the counter holds, and a count write loads the latch and the counter together, visible on the read port one edge later.
- R4: In timer mode the counter decrements once per source tick. A tick at count 0 reloads the latch value and sets the timer flag. A clear strobe resets the flag.
- R5: Source field 00 ticks once every 16 clocks, 01 once every 2 clocks, 10 on each clock with the oscillator enable high, and 11 never.
- R6: In event mode the counter decrements on synchronized pin rising edges when edge select = 0 and on falling edges when it is 1. The source ticks are ignored.
- R7: In timer, period and event modes the pin flag is set on falling pin edges when edge select = 0 and on rising edges when it is 1.
- R8: In period mode a falling edge (edge select 0) or a rising edge (edge select 1) captures the count and restarts the counter from the latch. The other edge has no effect.
- R9: While a capture is held the count port shows the capture, and later triggers do not overwrite it. A read strobe releases it, and the port then shows the live counter.
- R10: In high/low width mode both pin edges trigger a capture and set the pin flag, whatever edge select holds.
- R11: A pin change takes effect on the third rising clock edge after it, through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_en_i | input | 1 | Oscillator tick enable (source 10) |
| wdata_i | input | 8 | Write data for all registers |
| wr_mode_i | input | 1 | Write strobe, mode register |
| wr_src_i | input | 1 | Write strobe, source register |
| wr_cnt_i | input | 1 | Write strobe, reload latch (and counter when stopped) |
| rd_cnt_i | input | 1 | Count read strobe, releases a held capture |
| clr_tmr_irq_i | input | 1 | Clears the timer request flag |
| clr_pin_irq_i | input | 1 | Clears the pin request flag |
| pin_i | input | 1 | External count/measurement pin |
| mode_o | output | 8 | Mode register read-back |
| src_o | output | 8 | Source register read-back |
| cnt_o | output | 8 | Capture while held, else live count |
| tmr_irq_o | output | 1 | Underflow request flag |
| pin_irq_o | output | 1 | Pin edge request flag |

## Verification
A register write appears on the read ports one clock edge after its strobe. A source tick moves the counter at that same edge. Any pin change acts on the third edge after the bench drives it. The bench drives inputs just after a rising edge. It waits for the known number of edges, and only then pushes the expected value to the scoreboard, which compares it on the following falling edge. Pin steps are held for four cycles, so every edge effect has settled before the next check. The one exception is the check for the third-edge timing, which samples on the second and third edges.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER  = 2'b00,
    MODE_PERIOD = 2'b01,
    MODE_EVENT  = 2'b10,
    MODE_WIDTH  = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    SRC_DIV_SLOW = 2'b00,
    SRC_DIV_FAST = 2'b01,
    SRC_OSC      = 2'b10,
    SRC_OFF      = 2'b11
  } tmr_src_e;

  localparam int unsigned MODE_BITS = 4;
  localparam int unsigned SRC_BITS  = 2;
endpackage

// File: rtl/cap_timer_sync.sv
module cap_timer_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q[0] <= 1'b0;
        else         sh_q[0] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q[i] <= 1'b0;
        else         sh_q[i] <= sh_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sh_q[STAGES-1];

  assign rise_o = sh_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sh_q[STAGES-1] & prev_q;
endmodule

// File: rtl/cap_timer_presc.sv
module cap_timer_presc
  import cap_timer_pkg::*;
#(
  parameter int unsigned DIV_SLOW = 16,
  parameter int unsigned DIV_FAST = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  tmr_src_e src_i,
  input  logic     osc_en_i,
  output logic     tick_o
);
  localparam int unsigned PW = $clog2(DIV_SLOW);
  localparam int unsigned FW = $clog2(DIV_FAST);

  logic [PW-1:0] presc_q;
  logic          slow_tick, fast_tick;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) presc_q <= '0;
    else         presc_q <= presc_q + 1'b1;

  assign slow_tick = (presc_q == PW'(DIV_SLOW - 1));
  assign fast_tick = &presc_q[FW-1:0];

  always_comb begin
    unique case (src_i)
      SRC_DIV_SLOW: tick_o = slow_tick;
      SRC_DIV_FAST: tick_o = fast_tick;
      SRC_OSC:      tick_o = osc_en_i;
      default:      tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_SLOW    = 16,
  parameter int unsigned DIV_FAST    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_en_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             wr_mode_i,
  input  logic             wr_src_i,
  input  logic             wr_cnt_i,
  input  logic             rd_cnt_i,
  input  logic             clr_tmr_irq_i,
  input  logic             clr_pin_irq_i,
  input  logic             pin_i,
  output logic [CNT_W-1:0] mode_o,
  output logic [CNT_W-1:0] src_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tmr_irq_o,
  output logic             pin_irq_o
);
  logic [MODE_BITS-1:0] mode_q;
  logic [SRC_BITS-1:0]  src_q;
  logic [CNT_W-1:0]     latch_q, cnt_q, cap_q;
  logic                 cap_full_q, tmr_irq_q, pin_irq_q;
  logic                 rise, fall, src_tick;
  logic                 run, edge_sel, sel_edge, step, trig, pin_evt;
  tmr_mode_e            mode;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata_i[CNT_W-1:MODE_BITS];

  cap_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  cap_timer_presc #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (tmr_src_e'(src_q)),
    .osc_en_i(osc_en_i),
    .tick_o  (src_tick)
  );

  assign mode     = tmr_mode_e'(mode_q[1:0]);
  assign edge_sel = mode_q[2];
  assign run      = ~mode_q[3];
  // edge_sel=0: rising for counting, falling for period/interrupt
  assign sel_edge = edge_sel ? rise : fall;

  always_comb begin
    step    = 1'b0;
    trig    = 1'b0;
    pin_evt = sel_edge;
    unique case (mode)
      MODE_TIMER:  step = run & src_tick;
      MODE_EVENT:  step = run & (edge_sel ? fall : rise);
      MODE_PERIOD: begin
        step = run & src_tick;
        trig = run & sel_edge;
      end
      default: begin
        step    = run & src_tick;
        trig    = run & (rise | fall);
        pin_evt = rise | fall;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      src_q  <= '0;
    end else begin
      if (wr_mode_i) mode_q <= wdata_i[MODE_BITS-1:0];
      if (wr_src_i)  src_q  <= wdata_i[SRC_BITS-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '1;
      cnt_q   <= '1;
    end else begin
      if (wr_cnt_i) latch_q <= wdata_i;
      if (wr_cnt_i && !run)  cnt_q <= wdata_i;
      else if (trig)         cnt_q <= latch_q;
      else if (step)         cnt_q <= (cnt_q == '0) ? latch_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q      <= '0;
      cap_full_q <= 1'b0;
    end else if (trig && !cap_full_q) begin
      cap_q      <= cnt_q;
      cap_full_q <= 1'b1;
    end else if (rd_cnt_i) begin
      cap_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_irq_q <= 1'b0;
      pin_irq_q <= 1'b0;
    end else begin
      if (step && !trig && cnt_q == '0) tmr_irq_q <= 1'b1;
      else if (clr_tmr_irq_i)           tmr_irq_q <= 1'b0;
      if (pin_evt)            pin_irq_q <= 1'b1;
      else if (clr_pin_irq_i) pin_irq_q <= 1'b0;
    end
  end

  assign mode_o    = CNT_W'(mode_q);
  assign src_o     = CNT_W'(src_q);
  assign cnt_o     = cap_full_q ? cap_q : cnt_q;
  assign tmr_irq_o = tmr_irq_q;
  assign pin_irq_o = pin_irq_q;

  // R3
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_cnt_i) |=> $stable(cnt_q));

  // R4
  underflow_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !trig && cnt_q == '0 && !wr_cnt_i) |=> (cnt_q == $past(latch_q) && tmr_irq_o));

  // R9
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_full_q && !rd_cnt_i) |=> ($stable(cap_q) && cap_full_q));

  // R10
  width_both_edges_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_WIDTH && (rise || fall)) |=> pin_irq_o);

  // R8
  trig_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig && !(wr_cnt_i && !run)) |=> cnt_q == $past(latch_q));
endmodule

// File: tb/cap_timer_test.sv
`timescale 1ns/1ps
module cap_timer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       osc_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       wr_mode_i = 1'b0, wr_src_i = 1'b0, wr_cnt_i = 1'b0, rd_cnt_i = 1'b0;
  logic       clr_tmr_irq_i = 1'b0, clr_pin_irq_i = 1'b0, pin_i = 1'b0;
  logic [7:0] mode_o, src_o, cnt_o;
  logic       tmr_irq_o, pin_irq_o;

  int n_cmp = 0, n_bad = 0, wd = 0;

  typedef struct { string tag; int sel; logic [7:0] exp; } sb_item_t;
  sb_item_t sb_q[$];

  always #4 clk_i = ~clk_i;

  cap_timer uut (.*);

  // monitor: compare queued expectations against outputs
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      sb_item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.sel)
        0: act = cnt_o;
        1: act = mode_o;
        2: act = src_o;
        3: act = {7'b0, tmr_irq_o};
        default: act = {7'b0, pin_irq_o};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
      end
    end
  end

  always @(posedge clk_i) begin
    wd++;
    if (wd > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic expect_val(string tag, int sel, logic [7:0] exp);
    sb_item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic wr_mode(logic [7:0] d);
    wdata_i = d; wr_mode_i = 1'b1; step(1); wr_mode_i = 1'b0;
  endtask
  task automatic wr_src(logic [7:0] d);
    wdata_i = d; wr_src_i = 1'b1; step(1); wr_src_i = 1'b0;
  endtask
  task automatic wr_cnt(logic [7:0] d);
    wdata_i = d; wr_cnt_i = 1'b1; step(1); wr_cnt_i = 1'b0;
  endtask
  task automatic osc(int n);
    osc_en_i = 1'b1; step(n); osc_en_i = 1'b0;
  endtask
  task automatic pin(logic v);
    pin_i = v; step(4);
  endtask
  task automatic rd();
    rd_cnt_i = 1'b1; step(1); rd_cnt_i = 1'b0;
  endtask
  task automatic clr_pin();
    clr_pin_irq_i = 1'b1; step(1); clr_pin_irq_i = 1'b0;
  endtask

  initial begin
    step(2);
    rst_ni = 1'b1;
    step(1);
    expect_val("R1 mode", 1, 8'h00);
    expect_val("R1 src", 2, 8'h00);
    expect_val("R1 cnt", 0, 8'hFF);
    expect_val("R1 tmr_irq", 3, 8'h00);
    expect_val("R1 pin_irq", 4, 8'h00);
    step(1);

    wr_mode(8'hFF); expect_val("R2 mode unused bits", 1, 8'h0F);
    wr_src(8'hFF);  expect_val("R2 src unused bits", 2, 8'h03);
    step(1);

    // R3 stopped load and hold
    wr_src(8'h02); wr_mode(8'h08);
    wr_cnt(8'd5); expect_val("R3 load while stopped", 0, 8'd5);
    osc(3); expect_val("R3 stop holds", 0, 8'd5);
    step(1);

    // R4 underflow and reload
    wr_mode(8'h00);
    osc(5); expect_val("R4 count to zero", 0, 8'd0);
    expect_val("R4 no irq before underflow", 3, 8'd0);
    osc(1); expect_val("R4 reload", 0, 8'd5);
    expect_val("R4 irq set", 3, 8'd1);
    clr_tmr_irq_i = 1'b1; step(1); clr_tmr_irq_i = 1'b0;
    expect_val("R4 irq cleared", 3, 8'd0);
    step(1);

    // R5 sources
    wr_src(8'h03); osc(4); expect_val("R5 source off", 0, 8'd5);
    wr_mode(8'h08); wr_cnt(8'd20); wr_src(8'h01); wr_mode(8'h00);
    step(16); expect_val("R5 div2", 0, 8'd12);
    step(1);
    wr_mode(8'h08); wr_cnt(8'd40); wr_src(8'h00); wr_mode(8'h00);
    step(32); expect_val("R5 div16", 0, 8'd38);
    step(1);
    wr_mode(8'h08);

    // R6 event counting, R11 sync latency
    wr_mode(8'h0A); wr_cnt(8'd10); wr_mode(8'h02);
    pin_i = 1'b1; step(2); expect_val("R11 not yet at edge 2", 0, 8'd10);
    step(1); expect_val("R11 counted at edge 3", 0, 8'd9);
    step(1); pin(1'b0);
    pin(1'b1); pin(1'b0); pin(1'b1); pin(1'b0);
    expect_val("R6 rising counts", 0, 8'd7);
    expect_val("R7 event edge0 falling irq", 4, 8'd1);
    clr_pin();
    wr_mode(8'h06);
    pin(1'b1); expect_val("R6 rising ignored with edge1", 0, 8'd7);
    expect_val("R7 event edge1 rising irq", 4, 8'd1);
    pin(1'b0); expect_val("R6 falling counts", 0, 8'd6);

    // R7 timer mode edge0: rising gives no request
    wr_src(8'h03); wr_mode(8'h00); clr_pin();
    pin(1'b1); expect_val("R7 rising no irq", 4, 8'd0);
    pin(1'b0); expect_val("R7 falling irq", 4, 8'd1);
    clr_pin();

    // R8/R9 period measurement
    wr_src(8'h02); wr_mode(8'h09); wr_cnt(8'd100); wr_mode(8'h01);
    pin(1'b1); expect_val("R8 rising ignored", 0, 8'd100);
    osc(7); expect_val("R8 counting", 0, 8'd93);
    pin(1'b0); expect_val("R8 capture on falling", 0, 8'd93);
    expect_val("R7 period falling irq", 4, 8'd1);
    osc(3); pin(1'b1); osc(5); pin(1'b0);
    expect_val("R9 capture held", 0, 8'd93);
    rd(); expect_val("R9 released, R8 restarted", 0, 8'd100);
    step(1);

    // R10 width mode, edge select 0
    wr_mode(8'h0B); wr_cnt(8'd50); clr_pin(); wr_mode(8'h03);
    osc(4);
    pin(1'b1); expect_val("R10 rising capture", 0, 8'd46);
    expect_val("R10 rising irq", 4, 8'd1);
    rd(); expect_val("R10 restart after rise", 0, 8'd50);
    clr_pin(); osc(6);
    pin(1'b0); expect_val("R10 falling capture", 0, 8'd44);
    expect_val("R10 falling irq", 4, 8'd1);
    rd();
    step(3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule